// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sets the length of every flash read bus cycle. A 16-bit control register holds a small wait code. A sequencer turns each read request into a bus cycle: the base length for the request type plus the number of waits that the code selects. When the last cycle of the access is reached, the sequencer raises a single-cycle ready pulse to the CPU.

Instruction fetches and data reads have different base lengths. The wait code is offset and runs from high to low. The all-ones reset value gives the longest read. Code 1 adds no wait. Code 0 is reserved and is handled as the longest setting. The sequencer samples the code only when it accepts a request, so a register write never changes an access that is already under way.

Top module: `flash_wait_ctrl`

## Requirements
- R1: After reset the wait code is 3, `reg_rdata` reads 0x0003 and `ready` is low.
- R2: A register write stores `reg_wdata[1:0]` as the wait code, and that value reads back on `reg_rdata[1:0]` in the next cycle. Code 0 also reads back as 0.
- R3: `reg_rdata[15:2]` always reads 0, and a write ignores `reg_wdata[15:2]`.
- R4: A code selects a number of waits: code 3 gives 2 waits, code 2 gives 1 wait and code 1 gives no wait.
- R5: Code 0 gives 2 waits, the same as code 3.
- R6: An access lasts N = base + waits cycles. The base is 1 for a fetch (`req_is_data`=0) and 2 for a data read (`req_is_data`=1). The access is accepted at a rising edge where `req_valid` is high and the block is idle. Cycle 1 is the cycle that follows that edge, and `ready` is high only in cycle N.
- R7: `ready` is high for exactly one cycle per access. While an access is in progress, including its ready cycle, `req_valid` is ignored. A request that is held high is accepted in the cycle after ready.
- R8: The wait code is sampled when a request is accepted. A register write during an access leaves that access's length unchanged and applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (wait code in bits [1:0]) |
| req_valid | input | 1 | Flash read request |
| req_is_data | input | 1 | 1 = data read, 0 = instruction fetch |
| ready | output | 1 | One-cycle pulse that ends the bus cycle |

## Verification
The bench builds the block with its default parameters: a 16-bit register, a 2-bit code, a fetch base of 1 and a data base of 2. These defaults give access lengths from 1 cycle (a fetch with code 1) up to 4 cycles (a data read with code 3 or code 0), so every code can be checked with both request types. A request held high across several accesses shows the idle cycle between them. A write made in the middle of a 4-cycle data read shows that the access length was fixed when the request was accepted.

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl #(
  parameter int REG_W      = 16,
  parameter int WAIT_W     = 2,
  parameter int FETCH_BASE = 1,
  parameter int DATA_BASE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             req_valid,
  input  logic             req_is_data,
  output logic             ready
);
  localparam logic [WAIT_W-1:0] CODE_RST = '1;
  localparam int MAX_WAIT = (1 << WAIT_W) - 2;
  localparam int MAX_LEN  = ((DATA_BASE > FETCH_BASE) ? DATA_BASE : FETCH_BASE) + MAX_WAIT;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic [WAIT_W-1:0] code_q;
  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  wait_n, base_n, len_m1;
  logic              accept;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[REG_W-1:WAIT_W];

  assign wait_n = (code_q == '0) ? CNT_W'(MAX_WAIT) : CNT_W'(code_q) - CNT_W'(1);
  assign base_n = req_is_data ? CNT_W'(DATA_BASE) : CNT_W'(FETCH_BASE);
  assign len_m1 = base_n + wait_n - CNT_W'(1);
  assign accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_RST;
    end else if (reg_we) begin
      code_q <= reg_wdata[WAIT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= len_m1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  assign ready     = busy && (cnt == '0);
  assign reg_rdata = {{(REG_W-WAIT_W){1'b0}}, code_q};
endmodule

module flash_wait_ctrl_chk #(
  parameter int REG_W  = 16,
  parameter int WAIT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             ready,
  input logic             busy
);
  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R7
  idle_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !busy);

  // R6
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> busy);

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_rdata[WAIT_W-1:0] == $past(reg_wdata[WAIT_W-1:0])));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:WAIT_W] == '0);
endmodule

bind flash_wait_ctrl flash_wait_ctrl_chk #(.REG_W(REG_W), .WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ready(ready), .busy(busy)
);

// File: tb/flash_wait_ctrl_test.sv
module flash_wait_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_is_data = 1'b0;
  logic        ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_wait_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_is_data(req_is_data),
    .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  // Issues one request and returns the cycle in which ready is seen.
  task automatic access(input logic is_data, output int len);
    @(negedge clk); req_valid = 1'b1; req_is_data = is_data;
    @(negedge clk); req_valid = 1'b0;
    len = 1;
    while (!ready && len < 12) begin
      @(negedge clk); len++;
    end
  endtask

  task automatic t_reset;
    check("R1 rdata", int'(reg_rdata), 3);
    check("R1 ready", int'(ready), 0);
  endtask

  task automatic t_lengths;
    int len;
    int waits [4] = '{2, 0, 1, 2};
    for (int c = 3; c >= 0; c--) begin
      write_reg(16'hFFFC | 16'(c));
      check("R2/R3 readback", int'(reg_rdata), c);
      access(1'b0, len);
      check(c == 0 ? "R5 fetch len" : "R4/R6 fetch len", len, 1 + waits[c]);
      @(negedge clk);
      check("R7 pulse fetch", int'(ready), 0);
      access(1'b1, len);
      check(c == 0 ? "R5 data len" : "R4/R6 data len", len, 2 + waits[c]);
      @(negedge clk);
      check("R7 pulse data", int'(ready), 0);
    end
  endtask

  task automatic t_back_to_back;
    write_reg(16'h0001);
    @(negedge clk); req_valid = 1'b1; req_is_data = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R7 held request", int'(ready), k % 2);
    end
    req_valid = 1'b0;
    write_reg(16'h0002);
    @(negedge clk); req_valid = 1'b1; req_is_data = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R7 held data", int'(ready), (k == 3 || k == 7) ? 1 : 0);
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mid_write;
    int len;
    write_reg(16'h0003);
    @(negedge clk); req_valid = 1'b1; req_is_data = 1'b1;
    @(negedge clk); req_valid = 1'b0; reg_we = 1'b1; reg_wdata = 16'h0001;
    len = 1;
    @(negedge clk); reg_we = 1'b0; len++;
    check("R8 code updated", int'(reg_rdata), 1);
    while (!ready && len < 12) begin
      @(negedge clk); len++;
    end
    check("R8 length kept", len, 4);
    access(1'b1, len);
    check("R8 next access", len, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_lengths;
    t_back_to_back;
    t_mid_write;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule